// File: doc/BRIEF.md
# Virtqueue Available-Ring Descriptor Walker

This block serves the device side of a split virtqueue laid out in the fixed legacy format. The queue sits at a page-aligned base address given as a page frame number. When the driver signals a notify, the walker reads the driver's available-ring index through a simple one-outstanding memory read port. It compares that index with the last-seen index it holds, and for each new ring slot it fetches the head descriptor number. It then follows the descriptor chain.

Every device-readable descriptor becomes one address/length record on a valid/ready output stream. The chain's end is marked by a request-done record. That record carries the head index, plus either the index of the first write-only descriptor (where the reply will go) or a no-reply marker when the chain has none. An indirect descriptor, an out-of-range next index or an out-of-range head index raises a sticky error output and freezes the walker until reset.

Top module: `vq_avail_walker`

## Requirements
- R1: After a synchronous active-high reset, out_valid, rd_req_valid, err_indirect and err_range are low, and the last-seen index is 0, so the first request consumed afterwards comes from ring slot 0.
- R2: A notify while idle issues a read of the 32-bit little-endian word at (queue_pfn << 12) + 16*QSIZE. Bits [31:16] of that word are the driver's available index.
- R3: The driver index is reduced to its low log2(QSIZE) bits. One request is walked per ring slot while the last-seen index differs from it, and the last-seen index then steps by one modulo QSIZE. The index word is read again after every request-done record, so a walk of n requests takes 1 + sum(2 + 4*readable + write) reads.
- R4: Ring slot k is read from the word at base + 16*QSIZE + 4 + 4*(k>>1). The head index is bits [31:16] for odd k and bits [15:0] for even k.
- R5: For descriptor i the word at base + 16*i + 12 is read first (flags in [15:0], next index in [31:16]). For a readable descriptor the words at +0, +4 and +8 are read next, and a buffer record is emitted with out_done=0, out_addr={word +4, word +0}, out_len=word +8 and out_head=head index.
- R6: Flag bit 0 (next) makes the walker continue at the next index. A readable descriptor without it ends the chain with a record out_done=1, out_noreply=1, out_reply=0.
- R7: Flag bit 1 (write) stops the chain with no buffer record for that descriptor. The walker emits out_done=1, out_noreply=0, out_reply=that descriptor's index. Bit 2 is not looked at when bit 1 is set.
- R8: Flag bit 2 (indirect) with bit 1 clear raises err_indirect. Nothing is emitted for that descriptor, and no further read or record follows until reset.
- R9: A next index of QSIZE or more with bit 0 set, or a head index of QSIZE or more, raises err_range. It freezes the walker as in R8, and the offending descriptor's buffer is not emitted.
- R10: An output record is held unchanged while out_valid is high and out_ready low. A read address is held while rd_req_valid is high and rd_req_ready low. At most one read is outstanding.
- R11: A notify when the driver index equals the last-seen index causes exactly one read and no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (device reset) |
| notify | input | 1 | Queue notify pulse |
| queue_pfn | input | PFN_W | Queue page frame number |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | PFN_W+12 | Byte address of the 32-bit word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data, little-endian word |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Record accepted |
| out_done | output | 1 | 1 = request-done record, 0 = buffer record |
| out_noreply | output | 1 | Done record without a write-only descriptor |
| out_head | output | 16 | Head descriptor index of the request |
| out_reply | output | 16 | First write-only descriptor index |
| out_addr | output | 64 | Buffer address |
| out_len | output | 32 | Buffer length |
| err_indirect | output | 1 | Sticky: indirect descriptor seen |
| err_range | output | 1 | Sticky: head or next index out of range |

## Verification
The hardest situation to reach is the wrap of the ring and of the driver's free-running 16-bit index past the queue size, with chains whose next links also wrap around the descriptor table, all while both the read port and the output stream stall. A sweep of batches of one or two requests, with zero to two readable descriptors plus an optional write-only tail, moves the driver index well past several ring lengths. The chain start rotates through the table on every batch, and the read and record ready lines follow different periodic stall patterns. The error freezes are driven by placing flag and index values at the exact range boundary, and each freeze is followed by a reset that must bring the walker back to ring slot 0.

// File: rtl/vqw_pkg.sv
package vqw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_AVIDX, ST_AVENT, ST_DFLG, ST_DALO, ST_DAHI, ST_DLEN,
    ST_EBUF, ST_EDONE, ST_HALT
  } walk_st_t;

  localparam int FLG_NEXT  = 0;
  localparam int FLG_WRITE = 1;
  localparam int FLG_INDIR = 2;

  typedef struct packed {
    logic        done;
    logic        noreply;
    logic [15:0] head;
    logic [15:0] reply;
    logic [63:0] addr;
    logic [31:0] len;
  } vq_rec_t;

endpackage

// File: rtl/vqw_desc_decode.sv
module vqw_desc_decode #(
  parameter int QSIZE = 32,
  parameter int IDX_W = $clog2(QSIZE)
) (
  input  logic [2:0]       flags,
  input  logic [15:0]      next_raw,
  output logic             is_write,
  output logic             is_indir,
  output logic             has_next,
  output logic             next_bad,
  output logic [IDX_W-1:0] next_idx
);
  import vqw_pkg::*;

  always_comb begin
    is_write = flags[FLG_WRITE];
    is_indir = flags[FLG_INDIR];
    has_next = flags[FLG_NEXT];
    next_bad = flags[FLG_NEXT] && (32'(next_raw) >= 32'(QSIZE));
    next_idx = next_raw[IDX_W-1:0];
  end

endmodule

// File: rtl/vqw_idx_track.sv
module vqw_idx_track #(
  parameter int QSIZE = 32,
  parameter int IDX_W = $clog2(QSIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] avail_in,
  input  logic             adv,
  output logic [IDX_W-1:0] last_idx,
  output logic             work_now
);
  logic [IDX_W-1:0] avail_q;
  logic [IDX_W-1:0] last_q;

  assign last_idx = last_q;
  assign work_now = (avail_in != last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '0;
      last_q  <= '0;
    end else begin
      if (load) avail_q <= avail_in;
      if (adv)  last_q  <= last_q + 1'b1;
    end
  end

  // R3: a request is only retired while the stored driver index is ahead
  p_adv_has_work_r3: assert property (@(posedge clk) disable iff (rst)
    adv |-> (avail_q != last_q));

endmodule

// File: rtl/vqw_out_reg.sv
module vqw_out_reg
  import vqw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  output logic    in_ready,
  input  vq_rec_t in_rec,
  output logic    out_valid,
  input  logic    out_ready,
  output vq_rec_t out_rec
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) out_rec <= in_rec;
  end

  // R10: a stalled record keeps its contents
  p_rec_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

endmodule

// File: rtl/vq_avail_walker.sv
module vq_avail_walker #(
  parameter int QSIZE = 32,
  parameter int PFN_W = 20,
  localparam int ADDR_W = PFN_W + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              notify,
  input  logic [PFN_W-1:0]  queue_pfn,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_done,
  output logic              out_noreply,
  output logic [15:0]       out_head,
  output logic [15:0]       out_reply,
  output logic [63:0]       out_addr,
  output logic [31:0]       out_len,
  output logic              err_indirect,
  output logic              err_range
);
  import vqw_pkg::*;

  localparam int IDX_W    = $clog2(QSIZE);
  localparam int RING_OFF = QSIZE * 16;

  walk_st_t         st;
  logic             req_sent;
  logic             rsp_take;
  logic [IDX_W-1:0] cur, head, nxt, reply;
  logic             has_next_q, noreply;
  logic [31:0]      alo, ahi, blen;

  logic [IDX_W-1:0] last_idx;
  logic             work_now;
  logic             trk_load, trk_adv;

  logic             d_write, d_indir, d_next, d_bad;
  logic [IDX_W-1:0] d_idx;
  logic [15:0]      entry;

  logic [ADDR_W-1:0] base_a, ring_a, desc_a;

  logic    rec_valid, rec_ready;
  vq_rec_t rec_in, rec_out;

  // ---------------- address generation ----------------
  always_comb begin
    base_a = {queue_pfn, 12'h000};
    ring_a = base_a + ADDR_W'(RING_OFF);
    desc_a = base_a + ADDR_W'({cur, 4'h0});
    case (st)
      ST_AVIDX: rd_req_addr = ring_a;
      ST_AVENT: rd_req_addr = ring_a + ADDR_W'(4) + ADDR_W'({last_idx >> 1, 2'b00});
      ST_DFLG:  rd_req_addr = desc_a + ADDR_W'(12);
      ST_DALO:  rd_req_addr = desc_a;
      ST_DAHI:  rd_req_addr = desc_a + ADDR_W'(4);
      ST_DLEN:  rd_req_addr = desc_a + ADDR_W'(8);
      default:  rd_req_addr = '0;
    endcase
  end

  always_comb begin
    rd_req_valid = 1'b0;
    case (st)
      ST_AVIDX, ST_AVENT, ST_DFLG, ST_DALO, ST_DAHI, ST_DLEN: rd_req_valid = !req_sent;
      default: rd_req_valid = 1'b0;
    endcase
  end

  assign rsp_take = rd_rsp_valid && req_sent;
  assign entry    = last_idx[0] ? rd_rsp_data[31:16] : rd_rsp_data[15:0];

  always_ff @(posedge clk) begin
    if (rst) req_sent <= 1'b0;
    else if (rd_req_valid && rd_req_ready) req_sent <= 1'b1;
    else if (rsp_take) req_sent <= 1'b0;
  end

  // ---------------- sub-blocks ----------------
  assign trk_load = (st == ST_AVIDX) && rsp_take;
  assign trk_adv  = (st == ST_EDONE) && rec_ready;

  vqw_idx_track #(.QSIZE(QSIZE), .IDX_W(IDX_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (trk_load),
    .avail_in (rd_rsp_data[16 +: IDX_W]),
    .adv      (trk_adv),
    .last_idx (last_idx),
    .work_now (work_now)
  );

  vqw_desc_decode #(.QSIZE(QSIZE), .IDX_W(IDX_W)) u_dec (
    .flags    (rd_rsp_data[2:0]),
    .next_raw (rd_rsp_data[31:16]),
    .is_write (d_write),
    .is_indir (d_indir),
    .has_next (d_next),
    .next_bad (d_bad),
    .next_idx (d_idx)
  );

  always_comb begin
    rec_valid      = (st == ST_EBUF) || (st == ST_EDONE);
    rec_in.done    = (st == ST_EDONE);
    rec_in.noreply = (st == ST_EDONE) && noreply;
    rec_in.head    = 16'(head);
    rec_in.reply   = (st == ST_EDONE) ? 16'(reply) : 16'h0;
    rec_in.addr    = (st == ST_EDONE) ? 64'h0 : {ahi, alo};
    rec_in.len     = (st == ST_EDONE) ? 32'h0 : blen;
  end

  vqw_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rec_valid),
    .in_ready  (rec_ready),
    .in_rec    (rec_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rec   (rec_out)
  );

  assign out_done    = rec_out.done;
  assign out_noreply = rec_out.noreply;
  assign out_head    = rec_out.head;
  assign out_reply   = rec_out.reply;
  assign out_addr    = rec_out.addr;
  assign out_len     = rec_out.len;

  // ---------------- walk sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cur          <= '0;
      head         <= '0;
      nxt          <= '0;
      reply        <= '0;
      has_next_q   <= 1'b0;
      noreply      <= 1'b0;
      alo          <= '0;
      ahi          <= '0;
      blen         <= '0;
      err_indirect <= 1'b0;
      err_range    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (notify) st <= ST_AVIDX;
        ST_AVIDX: if (rsp_take) st <= work_now ? ST_AVENT : ST_IDLE;
        ST_AVENT: if (rsp_take) begin
          if (32'(entry) >= 32'(QSIZE)) begin
            err_range <= 1'b1;
            st        <= ST_HALT;
          end else begin
            cur  <= entry[IDX_W-1:0];
            head <= entry[IDX_W-1:0];
            st   <= ST_DFLG;
          end
        end
        ST_DFLG: if (rsp_take) begin
          if (d_write) begin
            reply   <= cur;
            noreply <= 1'b0;
            st      <= ST_EDONE;
          end else if (d_indir) begin
            err_indirect <= 1'b1;
            st           <= ST_HALT;
          end else if (d_bad) begin
            err_range <= 1'b1;
            st        <= ST_HALT;
          end else begin
            has_next_q <= d_next;
            nxt        <= d_idx;
            st         <= ST_DALO;
          end
        end
        ST_DALO: if (rsp_take) begin alo  <= rd_rsp_data; st <= ST_DAHI; end
        ST_DAHI: if (rsp_take) begin ahi  <= rd_rsp_data; st <= ST_DLEN; end
        ST_DLEN: if (rsp_take) begin blen <= rd_rsp_data; st <= ST_EBUF; end
        ST_EBUF: if (rec_ready) begin
          if (has_next_q) begin
            cur <= nxt;
            st  <= ST_DFLG;
          end else begin
            noreply <= 1'b1;
            reply   <= '0;
            st      <= ST_EDONE;
          end
        end
        ST_EDONE: if (rec_ready) st <= ST_AVIDX;
        ST_HALT:  st <= ST_HALT;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R10: request address held under back-pressure
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R10: no new request while a response is owed
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

  // R8: the indirect error is sticky until reset
  p_indir_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_indirect |=> err_indirect);

  // R9: after any error the read port stays silent
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (err_range || err_indirect) |-> !rd_req_valid);

endmodule

// File: tb/test_vq_avail_walker.sv
`timescale 1ns/1ps
module test_vq_avail_walker;
  localparam int QS    = 8;
  localparam int PFN_W = 20;
  localparam int BASE  = 32'h3000;
  localparam int RING  = BASE + 16 * QS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic notify = 1'b0;
  logic [PFN_W-1:0] queue_pfn = 20'h3;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [PFN_W+11:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic out_done, out_noreply;
  logic [15:0] out_head, out_reply;
  logic [63:0] out_addr;
  logic [31:0] out_len;
  logic err_indirect, err_range;

  always #2 clk = ~clk;

  vq_avail_walker #(.QSIZE(QS), .PFN_W(PFN_W)) i_vq_avail_walker (
    .clk(clk), .rst(rst), .notify(notify), .queue_pfn(queue_pfn),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_done(out_done),
    .out_noreply(out_noreply), .out_head(out_head), .out_reply(out_reply),
    .out_addr(out_addr), .out_len(out_len),
    .err_indirect(err_indirect), .err_range(err_range));

  logic [31:0] mem [0:4095];
  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0, slow_out = 0;

  bit pend = 0;
  logic [31:0] pend_a;
  int nlog = 0, ncap = 0;
  logic [31:0] alog [0:2047];
  bit          c_done [0:511];
  bit          c_nr   [0:511];
  int          c_head [0:511];
  int          c_rep  [0:511];
  logic [63:0] c_addr [0:511];
  logic [31:0] c_len  [0:511];

  // memory responder and record sink, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[pend_a[13:2]];
      pend = 0;
    end else rd_rsp_valid = 1'b0;
    rd_req_ready = (cyc % 3 != 0);
    if (rd_req_valid && rd_req_ready) begin
      pend = 1;
      pend_a = 32'(rd_req_addr);
      if (nlog < 2048) alog[nlog] = 32'(rd_req_addr);
      nlog++;
    end
    out_ready = slow_out ? (cyc % 4 == 0) : 1'b1;
    if (out_valid && out_ready && ncap < 512) begin
      c_done[ncap] = out_done; c_nr[ncap] = out_noreply;
      c_head[ncap] = int'(out_head); c_rep[ncap] = int'(out_reply);
      c_addr[ncap] = out_addr; c_len[ncap] = out_len;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr16(input int a, input logic [15:0] v);
    if (a[1]) mem[a[13:2]][31:16] = v; else mem[a[13:2]][15:0] = v;
  endtask

  task automatic set_desc(input int i, input logic [63:0] ad, input logic [31:0] ln,
                          input logic [15:0] fl, input logic [15:0] nx);
    int a;
    a = BASE + 16 * i;
    mem[a[13:2]] = ad[31:0];
    mem[(a + 4) >> 2 & 4095] = ad[63:32];
    mem[(a + 8) >> 2 & 4095] = ln;
    wr16(a + 12, fl);
    wr16(a + 14, nx);
  endtask

  task automatic kick(input int waitc);
    @(negedge clk); notify = 1'b1;
    @(negedge clk); notify = 1'b0;
    repeat (waitc) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  int e_last = 0;
  logic [15:0] e_avail = 16'h0;

  task automatic run_round(input int r);
    int n, rl, wr, d, c0, l0, nexp, xreads, head0, last0;
    bit          x_done [0:15];
    bit          x_nr   [0:15];
    int          x_head [0:15];
    int          x_rep  [0:15];
    logic [63:0] x_addr [0:15];
    logic [31:0] x_len  [0:15];
    n  = 1 + (r % 2);
    rl = (r / 2) % 3;
    wr = (r / 6) % 2;
    if (rl == 0 && wr == 0) rl = 1;
    d = r % QS; nexp = 0; xreads = 1; head0 = d; last0 = e_last;
    c0 = ncap; l0 = nlog;
    for (int j = 0; j < n; j++) begin
      int h, cd;
      h = d;
      wr16(RING + 4 + 2 * ((e_last + j) % QS), 16'(h));
      for (int k = 0; k < rl; k++) begin
        logic [63:0] ad;
        logic [31:0] ln;
        cd = d; d = (d + 1) % QS;
        ad = {8'hA0 + 8'(r), 8'(j), 16'(k), 32'h1000 * r + 64 * j + k};
        ln = 100 + 7 * r + k;
        set_desc(cd, ad, ln, (k < rl - 1 || wr != 0) ? 16'h1 : 16'h0, 16'(d));
        x_done[nexp] = 0; x_nr[nexp] = 0; x_head[nexp] = h; x_rep[nexp] = 0;
        x_addr[nexp] = ad; x_len[nexp] = ln; nexp++;
      end
      if (wr != 0) begin
        set_desc(d, 64'h0, 32'h0, (r % 2 != 0) ? 16'h6 : 16'h2, 16'hFFFF);
        x_done[nexp] = 1; x_nr[nexp] = 0; x_head[nexp] = h; x_rep[nexp] = d;
        d = (d + 1) % QS;
      end else begin
        x_done[nexp] = 1; x_nr[nexp] = 1; x_head[nexp] = h; x_rep[nexp] = 0;
      end
      x_addr[nexp] = 0; x_len[nexp] = 0; nexp++;
      xreads += 2 + 4 * rl + wr;
    end
    e_avail = e_avail + 16'(n);
    wr16(RING + 2, e_avail);
    e_last = (e_last + n) % QS;
    slow_out = (r % 3 == 1);
    kick(300);
    chk(ncap - c0 == nexp, "R3 record count", 64'(ncap - c0), 64'(nexp));
    chk(nlog - l0 == xreads, "R3 read count", 64'(nlog - l0), 64'(xreads));
    chk(alog[l0] == RING, "R2 index word address", 64'(alog[l0]), 64'(RING));
    chk(alog[l0 + 1] == RING + 4 + 4 * (last0 >> 1), "R4 ring slot address",
        64'(alog[l0 + 1]), 64'(RING + 4 + 4 * (last0 >> 1)));
    chk(alog[l0 + 2] == BASE + 16 * head0 + 12, "R5 flags word address",
        64'(alog[l0 + 2]), 64'(BASE + 16 * head0 + 12));
    for (int i = 0; i < nexp && i < ncap - c0; i++) begin
      int c;
      c = c0 + i;
      chk(c_done[c] == x_done[i] && c_nr[c] == x_nr[i], "R6 record kind",
          {62'b0, c_done[c], c_nr[c]}, {62'b0, x_done[i], x_nr[i]});
      chk(c_head[c] == x_head[i], "R5 head index", 64'(c_head[c]), 64'(x_head[i]));
      if (x_done[i]) begin
        chk(c_rep[c] == x_rep[i], "R7 reply index", 64'(c_rep[c]), 64'(x_rep[i]));
      end else begin
        chk(c_addr[c] == x_addr[i], "R5 buffer address R10", c_addr[c], x_addr[i]);
        chk(c_len[c] == x_len[i], "R5 buffer length", 64'(c_len[c]), 64'(x_len[i]));
      end
    end
  endtask

  initial begin
    int c0, l0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !rd_req_valid, "R1 idle after reset", {62'b0, out_valid, rd_req_valid}, 64'h0);
    chk(!err_indirect && !err_range, "R1 errors clear", {62'b0, err_indirect, err_range}, 64'h0);

    // no pending work: one index read only
    l0 = nlog; c0 = ncap;
    kick(60);
    chk(nlog - l0 == 1 && ncap == c0, "R11 empty notify", 64'(nlog - l0), 64'h1);

    for (int r = 0; r < 24; r++) run_round(r);
    slow_out = 0;

    // next index at the range boundary
    wr16(RING + 4 + 2 * e_last, 16'h2);
    set_desc(2, 64'h55, 32'h9, 16'h1, 16'(QS));
    e_avail = e_avail + 1'b1;
    wr16(RING + 2, e_avail);
    c0 = ncap;
    kick(120);
    chk(err_range == 1'b1, "R9 next out of range", 64'(err_range), 64'h1);
    chk(err_indirect == 1'b0, "R9 no indirect flag", 64'(err_indirect), 64'h0);
    chk(ncap == c0, "R9 buffer withheld", 64'(ncap - c0), 64'h0);
    l0 = nlog;
    kick(60);
    chk(nlog == l0, "R9 frozen after error", 64'(nlog - l0), 64'h0);

    // device reset: errors clear, walking restarts at slot 0
    do_reset;
    chk(!err_range && !err_indirect && !out_valid && !rd_req_valid, "R1 reset clears",
        {60'b0, err_range, err_indirect, out_valid, rd_req_valid}, 64'h0);
    e_avail = 16'h1;
    wr16(RING + 2, e_avail);
    wr16(RING + 4, 16'h5);
    wr16(RING + 6, 16'h7);
    set_desc(5, 64'h1_2345_6780, 32'h40, 16'h0, 16'h0);
    c0 = ncap;
    kick(120);
    chk(ncap - c0 == 2, "R1 restart count", 64'(ncap - c0), 64'h2);
    chk(c_head[c0] == 5 && c_addr[c0] == 64'h1_2345_6780 && c_len[c0] == 32'h40,
        "R1 restart from slot 0", c_addr[c0], 64'h1_2345_6780);
    chk(c_done[c0 + 1] && c_nr[c0 + 1] && c_head[c0 + 1] == 5, "R6 end without next",
        {62'b0, c_done[c0 + 1], c_nr[c0 + 1]}, 64'h3);

    // indirect descriptor on slot 1
    wr16(RING + 6, 16'h3);
    set_desc(3, 64'h99, 32'h10, 16'h4, 16'h0);
    e_avail = 16'h2;
    wr16(RING + 2, e_avail);
    c0 = ncap;
    kick(120);
    chk(err_indirect == 1'b1, "R8 indirect flagged", 64'(err_indirect), 64'h1);
    chk(err_range == 1'b0, "R8 no range flag", 64'(err_range), 64'h0);
    chk(ncap == c0, "R8 nothing emitted", 64'(ncap - c0), 64'h0);
    l0 = nlog;
    kick(60);
    chk(nlog == l0, "R8 frozen after error", 64'(nlog - l0), 64'h0);

    // head index out of range
    do_reset;
    wr16(RING + 4, 16'(QS));
    wr16(RING + 2, 16'h1);
    c0 = ncap;
    kick(120);
    chk(err_range == 1'b1 && ncap == c0, "R9 head out of range", 64'(err_range), 64'h1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule